// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block decides which of four DMA channels gets serviced and supplies, for each serviced channel, everything a data mover needs: a channel identifier, the position already reached, the full block length and the physical memory address. A pass visits the channels one at a time in ascending order. A channel is serviced only if its mask bit is clear and its request flag is set. For each serviced channel the block raises a transfer request and waits for the mover to accept it. On acceptance it stores the new position returned by the mover. When that position equals the block length, the channel's terminal-count flag is set.

A small page-register file holds a low and a high page byte per channel. It is reached through a three-bit port offset that maps onto channels in a fixed, non-linear way. The memory address is built from the high page (seven bits used), the low page and the channel's current address. In decrement mode the address points below the current address instead of above it. A rescan pulse starts a pass. A rescan pulse that arrives while a pass is running causes exactly one more pass after the current one.

Top module: `dma_svc_sched`

## Requirements
- R1: A channel is offered for transfer only when its `ch_mask` bit is 0 and its `ch_req` bit is 1 at the moment the scan reaches it; masked or non-requesting channels are skipped.
- R2: Within one pass the channels are offered in ascending order 0, 1, 2, 3, each at most once per pass.
- R3: `xfer_len` equals (base count + 1) shifted left by `WSHIFT`, and `xfer_id` equals channel + 4 × `WSHIFT` (bit 2 carries the word shift, bits 1:0 the channel).
- R4: `xfer_pos` presents the last position accepted for that channel, 0 after reset; a `pos_clr` bit returns that channel's position to 0.
- R5: When an accepted `xfer_ret` equals `xfer_len`, that channel's `tc_flag` bit is set on the next clock and stays set until its `tc_clr` bit is pulsed; a return below the length leaves it clear.
- R6: Page offsets map to channels as 1→2, 2→3, 3→1, 7→0. Offsets 0, 4, 5 and 6 are unmapped: writes to them change no page register, and reads from them return 0. `pg_hi` = 1 selects the high page and 0 the low page.
- R7: With the channel's `ch_dec` bit 0, `xfer_addr` = {high page[6:0], low page, current address} + position, modulo 2^31.
- R8: With the channel's `ch_dec` bit 1, `xfer_addr` = {high page[6:0], low page, current address} − position − length, modulo 2^31.
- R9: `xfer_valid` stays high, with `xfer_id` and `xfer_pos` stable, until `xfer_ready` is seen. A `rescan` pulse during a pass causes one further pass. Without one, the block returns to idle (`busy` low) once channel 3 has been passed.
- R10: After reset `busy`, `xfer_valid` and `tc_flag` are 0, all positions are 0 and all page registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_mask | input | 4 | Per-channel mask, 1 = disabled |
| ch_req | input | 4 | Per-channel request flag |
| ch_dec | input | 4 | Per-channel decrement-address mode |
| base_cnt | input | 4×CNT_W | Base counts, channel n in slice n |
| cur_addr | input | 4×CNT_W | Current addresses, channel n in slice n |
| rescan | input | 1 | Pulse to start a pass, or to rearm one during a pass |
| pos_clr | input | 4 | Per-channel position clear |
| tc_clr | input | 4 | Per-channel terminal-count clear |
| pg_we | input | 1 | Page register write strobe |
| pg_hi | input | 1 | 1 selects high page, 0 low page |
| pg_off | input | 3 | Page port offset |
| pg_wdata | input | 8 | Page write data |
| pg_rdata | output | 8 | Page read data for pg_off/pg_hi |
| xfer_valid | output | 1 | Transfer request for the scanned channel |
| xfer_ready | input | 1 | Mover accepts request and xfer_ret |
| xfer_id | output | 3 | Channel + 4 × word shift |
| xfer_pos | output | CNT_W+1+WSHIFT | Position reached so far |
| xfer_len | output | CNT_W+1+WSHIFT | Full block length |
| xfer_addr | output | 31 | Composed physical address |
| xfer_ret | input | CNT_W+1+WSHIFT | Updated position from the mover |
| tc_flag | output | 4 | Terminal-count flags |
| busy | output | 1 | A pass is in progress |

## Verification
The assertions assume the mover keeps `xfer_ret` meaningful only when `xfer_ready` is high. They also assume that mask and request inputs do not change in the very cycle a channel is being scanned. The eligibility property therefore compares against the previous cycle's inputs. The bench drives all inputs at the falling edge and changes mask, request and mode settings only while `busy` is low or while a request is already held. A rescan pulse is issued only while a transfer request is pending, so that it falls inside a pass.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int NCH = 4;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_SCAN = 2'd1,
    SC_XFER = 2'd2
  } scan_st_e;

  // Page port decode: {hit, channel[1:0]}
  function automatic logic [2:0] page_slot(input logic [2:0] off);
    logic [2:0] r;
    case (off)
      3'd1:    r = {1'b1, 2'd2};
      3'd2:    r = {1'b1, 2'd3};
      3'd3:    r = {1'b1, 2'd1};
      3'd7:    r = {1'b1, 2'd0};
      default: r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_page_file.sv
module dma_page_file
  import dma_sched_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  sel_hi,
  input  logic [2:0]            off,
  input  logic [PAGE_W-1:0]     wdata,
  output logic [PAGE_W-1:0]     rdata,
  output logic [NCH*PAGE_W-1:0] lo_pages,
  output logic [NCH*PAGE_W-1:0] hi_pages
);

  logic [2:0] slot;
  logic       hit;
  logic [1:0] sch;

  assign slot = page_slot(off);
  assign hit  = slot[2];
  assign sch  = slot[1:0];

  logic [PAGE_W-1:0] lo_q [NCH];
  logic [PAGE_W-1:0] hi_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_page
    logic              lo_en, hi_en;
    logic [PAGE_W-1:0] lo_d, hi_d;

    always_comb begin
      lo_en = we && hit && (sch == 2'(g)) && !sel_hi;
      hi_en = we && hit && (sch == 2'(g)) &&  sel_hi;
      lo_d  = lo_en ? wdata : lo_q[g];
      hi_d  = hi_en ? wdata : hi_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else begin
        lo_q[g] <= lo_d;
        hi_q[g] <= hi_d;
      end
    end

    assign lo_pages[g*PAGE_W +: PAGE_W] = lo_q[g];
    assign hi_pages[g*PAGE_W +: PAGE_W] = hi_q[g];
  end

  always_comb begin
    if (!hit)        rdata = '0;
    else if (sel_hi) rdata = hi_q[sch];
    else             rdata = lo_q[sch];
  end

endmodule

// File: rtl/dma_chan_track.sv
module dma_chan_track
  import dma_sched_pkg::*;
#(
  parameter int POS_W = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [1:0]           upd_ch,
  input  logic [POS_W-1:0]     upd_pos,
  input  logic                 upd_tc,
  input  logic [NCH-1:0]       pos_clr,
  input  logic [NCH-1:0]       tc_clr,
  output logic [NCH*POS_W-1:0] pos_all,
  output logic [NCH-1:0]       tc
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [POS_W-1:0] pos_q, pos_d;
    logic             tc_q, tc_d;
    logic             hit;

    always_comb begin
      hit   = upd_en && (upd_ch == 2'(g));
      pos_d = pos_q;
      if (pos_clr[g])  pos_d = '0;
      else if (hit)    pos_d = upd_pos;
      tc_d = tc_q;
      if (tc_clr[g])   tc_d = 1'b0;
      if (hit && upd_tc) tc_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q <= '0;
        tc_q  <= 1'b0;
      end else begin
        pos_q <= pos_d;
        tc_q  <= tc_d;
      end
    end

    assign pos_all[g*POS_W +: POS_W] = pos_q;
    assign tc[g] = tc_q;
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int HPAGE_W = 7,
  parameter int PAGE_W  = 8,
  parameter int CNT_W   = 16,
  parameter int POS_W   = 17,
  localparam int ADDR_W = HPAGE_W + PAGE_W + CNT_W
) (
  input  logic [PAGE_W-1:0] hi_page,
  input  logic [PAGE_W-1:0] lo_page,
  input  logic [CNT_W-1:0]  cur,
  input  logic              dec,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  len,
  output logic [ADDR_W-1:0] addr
);

  localparam int FULL_W = PAGE_W + PAGE_W + CNT_W;

  logic [FULL_W-1:0] base_full;
  logic [FULL_W-1:0] pos_x, len_x, sum_full;
  logic [FULL_W-ADDR_W-1:0] unused_hi;

  always_comb begin
    base_full = {hi_page, lo_page, cur};
    pos_x     = FULL_W'(pos);
    len_x     = FULL_W'(len);
    if (dec) sum_full = base_full - pos_x - len_x;
    else     sum_full = base_full + pos_x;
  end

  // High page bits above HPAGE_W fall off with the truncation
  assign {unused_hi, addr} = sum_full;

endmodule

// File: rtl/dma_scan_ctl.sv
module dma_scan_ctl
  import dma_sched_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rescan,
  input  logic [NCH-1:0] elig,
  input  logic           xfer_ready,
  output logic           xfer_valid,
  output logic           accept,
  output logic [1:0]     cur_ch,
  output logic           busy
);

  localparam logic [1:0] LAST = 2'(NCH - 1);

  scan_st_e   st_q, st_d;
  logic [1:0] idx_q, idx_d;
  logic       rearm_q, rearm_d;
  logic       end_pass;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    rearm_d  = rearm_q;
    accept   = 1'b0;
    end_pass = 1'b0;
    case (st_q)
      SC_IDLE: begin
        if (rescan) begin
          st_d    = SC_SCAN;
          idx_d   = '0;
          rearm_d = 1'b0;
        end
      end
      SC_SCAN: begin
        if (rescan) rearm_d = 1'b1;
        if (elig[idx_q])         st_d = SC_XFER;
        else if (idx_q == LAST)  end_pass = 1'b1;
        else                     idx_d = idx_q + 2'd1;
      end
      SC_XFER: begin
        if (rescan) rearm_d = 1'b1;
        if (xfer_ready) begin
          accept = 1'b1;
          if (idx_q == LAST) end_pass = 1'b1;
          else begin
            idx_d = idx_q + 2'd1;
            st_d  = SC_SCAN;
          end
        end
      end
      default: st_d = SC_IDLE;
    endcase
    if (end_pass) begin
      if (rearm_q || rescan) begin
        st_d    = SC_SCAN;
        idx_d   = '0;
        rearm_d = 1'b0;
      end else begin
        st_d    = SC_IDLE;
        rearm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SC_IDLE;
      idx_q   <= '0;
      rearm_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      rearm_q <= rearm_d;
    end
  end

  assign xfer_valid = (st_q == SC_XFER);
  assign cur_ch     = idx_q;
  assign busy       = (st_q != SC_IDLE);

endmodule

// File: rtl/dma_svc_sched.sv
module dma_svc_sched
  import dma_sched_pkg::*;
#(
  parameter int WSHIFT  = 0,
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int HPAGE_W = 7,
  localparam int POS_W  = CNT_W + 1 + WSHIFT,
  localparam int ADDR_W = HPAGE_W + PAGE_W + CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       ch_mask,
  input  logic [NCH-1:0]       ch_req,
  input  logic [NCH-1:0]       ch_dec,
  input  logic [NCH*CNT_W-1:0] base_cnt,
  input  logic [NCH*CNT_W-1:0] cur_addr,
  input  logic                 rescan,
  input  logic [NCH-1:0]       pos_clr,
  input  logic [NCH-1:0]       tc_clr,
  input  logic                 pg_we,
  input  logic                 pg_hi,
  input  logic [2:0]           pg_off,
  input  logic [PAGE_W-1:0]    pg_wdata,
  output logic [PAGE_W-1:0]    pg_rdata,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic [2:0]           xfer_id,
  output logic [POS_W-1:0]     xfer_pos,
  output logic [POS_W-1:0]     xfer_len,
  output logic [ADDR_W-1:0]    xfer_addr,
  input  logic [POS_W-1:0]     xfer_ret,
  output logic [NCH-1:0]       tc_flag,
  output logic                 busy
);

  localparam logic SHIFT_BIT = (WSHIFT != 0);

  logic [NCH-1:0]        elig;
  logic                  accept;
  logic [1:0]            cur_ch;
  logic [NCH*PAGE_W-1:0] lo_pages, hi_pages;
  logic [NCH*POS_W-1:0]  pos_all;
  logic [CNT_W-1:0]      sel_cnt;
  logic [CNT_W:0]        cnt_p1;
  logic                  hit_tc;

  assign elig = ~ch_mask & ch_req;

  dma_scan_ctl u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .rescan     (rescan),
    .elig       (elig),
    .xfer_ready (xfer_ready),
    .xfer_valid (xfer_valid),
    .accept     (accept),
    .cur_ch     (cur_ch),
    .busy       (busy)
  );

  dma_page_file #(.PAGE_W(PAGE_W)) u_pages (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (pg_we),
    .sel_hi   (pg_hi),
    .off      (pg_off),
    .wdata    (pg_wdata),
    .rdata    (pg_rdata),
    .lo_pages (lo_pages),
    .hi_pages (hi_pages)
  );

  always_comb begin
    sel_cnt  = base_cnt[cur_ch*CNT_W +: CNT_W];
    cnt_p1   = {1'b0, sel_cnt} + {{CNT_W{1'b0}}, 1'b1};
    xfer_len = POS_W'(cnt_p1) << WSHIFT;
    xfer_pos = pos_all[cur_ch*POS_W +: POS_W];
    xfer_id  = {SHIFT_BIT, cur_ch};
    hit_tc   = (xfer_ret == xfer_len);
  end

  dma_chan_track #(.POS_W(POS_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (accept),
    .upd_ch  (cur_ch),
    .upd_pos (xfer_ret),
    .upd_tc  (hit_tc),
    .pos_clr (pos_clr),
    .tc_clr  (tc_clr),
    .pos_all (pos_all),
    .tc      (tc_flag)
  );

  dma_addr_gen #(
    .HPAGE_W (HPAGE_W),
    .PAGE_W  (PAGE_W),
    .CNT_W   (CNT_W),
    .POS_W   (POS_W)
  ) u_addr (
    .hi_page (hi_pages[cur_ch*PAGE_W +: PAGE_W]),
    .lo_page (lo_pages[cur_ch*PAGE_W +: PAGE_W]),
    .cur     (cur_addr[cur_ch*CNT_W +: CNT_W]),
    .dec     (ch_dec[cur_ch]),
    .pos     (xfer_pos),
    .len     (xfer_len),
    .addr    (xfer_addr)
  );

endmodule

// File: rtl/dma_svc_sched_chk.sv
module dma_svc_sched_chk #(
  parameter int POS_W  = 17,
  parameter int WSHIFT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ch_mask,
  input logic [3:0]       ch_req,
  input logic [2:0]       pg_off,
  input logic [7:0]       pg_rdata,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [2:0]       xfer_id,
  input logic [POS_W-1:0] xfer_pos,
  input logic [POS_W-1:0] xfer_len,
  input logic [POS_W-1:0] xfer_ret,
  input logic [3:0]       tc_flag,
  input logic             busy
);

  localparam logic SHIFT_BIT = (WSHIFT != 0);

  // R1: a new request only for a channel that was unmasked and requesting
  a_r1_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |->
      ((~$past(ch_mask) & $past(ch_req) & (4'b0001 << xfer_id[1:0])) != 4'b0000));

  // R3: identifier carries the word shift in its upper bit
  a_r3_id_shift: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_id[2] == SHIFT_BIT));

  // R5: full-length return sets that channel's terminal count
  a_r5_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && (xfer_ret == xfer_len)) |=>
      ((tc_flag & (4'b0001 << $past(xfer_id[1:0]))) != 4'b0000));

  // R6: unmapped page offsets read as zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_off == 3'd0 || pg_off == 3'd4 || pg_off == 3'd5 || pg_off == 3'd6)
      |-> (pg_rdata == 8'h00));

  // R9: request held stable until accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_id) && $stable(xfer_pos)));

  // R9: no request outside a pass
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xfer_valid);

endmodule

bind dma_svc_sched dma_svc_sched_chk #(
  .POS_W  (POS_W),
  .WSHIFT (WSHIFT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_mask    (ch_mask),
  .ch_req     (ch_req),
  .pg_off     (pg_off),
  .pg_rdata   (pg_rdata),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_id    (xfer_id),
  .xfer_pos   (xfer_pos),
  .xfer_len   (xfer_len),
  .xfer_ret   (xfer_ret),
  .tc_flag    (tc_flag),
  .busy       (busy)
);

// File: tb/test_dma_svc_sched.sv
module test_dma_svc_sched;

  localparam int CNT_W = 16;
  localparam int POS_W = 17;

  logic              clk, rst_n;
  logic [3:0]        ch_mask, ch_req, ch_dec, pos_clr, tc_clr;
  logic [4*CNT_W-1:0] base_cnt, cur_addr;
  logic              rescan, pg_we, pg_hi;
  logic [2:0]        pg_off;
  logic [7:0]        pg_wdata, pg_rdata;
  logic              xfer_valid, xfer_ready;
  logic [2:0]        xfer_id;
  logic [POS_W-1:0]  xfer_pos, xfer_len, xfer_ret;
  logic [30:0]       xfer_addr;
  logic [3:0]        tc_flag;
  logic              busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  dma_svc_sched i_dma_svc_sched (
    .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .ch_req(ch_req),
    .ch_dec(ch_dec), .base_cnt(base_cnt), .cur_addr(cur_addr),
    .rescan(rescan), .pos_clr(pos_clr), .tc_clr(tc_clr),
    .pg_we(pg_we), .pg_hi(pg_hi), .pg_off(pg_off), .pg_wdata(pg_wdata),
    .pg_rdata(pg_rdata), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_id(xfer_id), .xfer_pos(xfer_pos), .xfer_len(xfer_len),
    .xfer_addr(xfer_addr), .xfer_ret(xfer_ret), .tc_flag(tc_flag),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  // Wait (sampling at negedge) for a pending request
  task automatic wait_valid(input string req);
    int n = 0;
    while (!xfer_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(xfer_valid, req, {31'd0, xfer_valid}, 32'd1);
  endtask

  task automatic accept(input logic [POS_W-1:0] ret);
    xfer_ready = 1'b1;
    xfer_ret   = ret;
    @(posedge clk);
    @(negedge clk);
    xfer_ready = 1'b0;
    xfer_ret   = '0;
  endtask

  task automatic pulse_rescan();
    rescan = 1'b1;
    @(negedge clk);
    rescan = 1'b0;
  endtask

  task automatic page_wr(input logic hi, input logic [2:0] off,
                         input logic [7:0] d);
    pg_we = 1'b1; pg_hi = hi; pg_off = off; pg_wdata = d;
    @(negedge clk);
    pg_we = 1'b0;
  endtask

  task automatic page_rd(input logic hi, input logic [2:0] off,
                         input string req, input logic [7:0] exp);
    pg_hi = hi; pg_off = off;
    #1;
    chk_eq(req, {24'd0, pg_rdata}, {24'd0, exp});
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [30:0] mk_addr(input logic [7:0] hi, input logic [7:0] lo,
                                          input logic [15:0] cur);
    return {hi[6:0], lo, cur};
  endfunction

  // R10: reset state
  task automatic t_reset();
    chk_eq("R10 busy", {31'd0, busy}, 32'd0);
    chk_eq("R10 valid", {31'd0, xfer_valid}, 32'd0);
    chk_eq("R10 tc", {28'd0, tc_flag}, 32'd0);
    page_rd(1'b0, 3'd7, "R10 page low ch0", 8'h00);
    page_rd(1'b1, 3'd1, "R10 page high ch2", 8'h00);
  endtask

  // R6: page map, unmapped offsets
  task automatic t_pages();
    page_wr(1'b0, 3'd7, 8'h12);
    page_wr(1'b0, 3'd3, 8'h78);
    page_wr(1'b0, 3'd1, 8'h34);
    page_wr(1'b0, 3'd2, 8'h56);
    page_wr(1'b1, 3'd7, 8'hFF);
    page_wr(1'b1, 3'd3, 8'h05);
    page_wr(1'b0, 3'd4, 8'hAA);
    page_wr(1'b1, 3'd0, 8'hBB);
    page_wr(1'b0, 3'd6, 8'hCC);
    page_rd(1'b0, 3'd4, "R6 unmapped read 4", 8'h00);
    page_rd(1'b1, 3'd0, "R6 unmapped read 0", 8'h00);
    page_rd(1'b0, 3'd7, "R6 offset7 low", 8'h12);
    page_rd(1'b0, 3'd3, "R6 offset3 low", 8'h78);
    page_rd(1'b0, 3'd1, "R6 offset1 low", 8'h34);
    page_rd(1'b0, 3'd2, "R6 offset2 low", 8'h56);
    page_rd(1'b1, 3'd7, "R6 offset7 high", 8'hFF);
    page_rd(1'b1, 3'd3, "R6 offset3 high", 8'h05);
    page_rd(1'b1, 3'd1, "R6 offset1 high untouched", 8'h00);
    pg_off = 3'd0;
  endtask

  // R2, R1, R3, R7: ordered pass skipping masked channel
  task automatic t_order();
    ch_mask = 4'b0010; ch_req = 4'b1111; ch_dec = 4'b0000;
    @(negedge clk);
    pulse_rescan();
    wait_valid("R2 first request");
    chk_eq("R2 first id", {29'd0, xfer_id}, 32'd0);
    chk_eq("R3 len ch0", {15'd0, xfer_len}, 32'd4);
    chk_eq("R4 pos ch0 initial", {15'd0, xfer_pos}, 32'd0);
    chk_eq("R7 addr ch0", {1'b0, xfer_addr}, {1'b0, mk_addr(8'hFF, 8'h12, 16'h1000)});
    accept(17'd1);
    wait_valid("R2 second request");
    chk_eq("R1 R2 second id skips masked", {29'd0, xfer_id}, 32'd2);
    chk_eq("R3 len ch2", {15'd0, xfer_len}, 32'h101);
    accept(17'd1);
    wait_valid("R2 third request");
    chk_eq("R2 third id", {29'd0, xfer_id}, 32'd3);
    chk_eq("R3 len ch3", {15'd0, xfer_len}, 32'h10000);
    accept(17'd1);
    wait_idle();
    chk_eq("R9 idle after pass", {31'd0, busy}, 32'd0);
    chk_eq("R5 tc clear on short return", {28'd0, tc_flag}, 32'd0);
    ch_req = 4'b0000; ch_mask = 4'b1111;
  endtask

  // R9, R4, R5, R7: rearm during pass, position carry, terminal count
  task automatic t_rearm();
    ch_mask = 4'b1101; ch_req = 4'b0010;
    @(negedge clk);
    pulse_rescan();
    wait_valid("R9 ch1 request");
    chk_eq("R1 id ch1", {29'd0, xfer_id}, 32'd1);
    chk_eq("R7 addr ch1", {1'b0, xfer_addr},
           {1'b0, mk_addr(8'h05, 8'h78, 16'h2000)});
    pulse_rescan();
    chk_eq("R9 held until ready", {31'd0, xfer_valid}, 32'd1);
    accept(17'd5);
    wait_valid("R9 rearmed pass");
    chk_eq("R4 pos carried", {15'd0, xfer_pos}, 32'd5);
    chk_eq("R7 addr with pos", {1'b0, xfer_addr},
           {1'b0, mk_addr(8'h05, 8'h78, 16'h2005)});
    accept(17'h10);
    chk_eq("R5 tc set ch1", {28'd0, tc_flag}, 32'b0010);
    wait_idle();
    repeat (5) @(negedge clk);
    chk_eq("R9 no extra pass", {31'd0, busy | xfer_valid}, 32'd0);
    chk_eq("R5 tc sticky", {28'd0, tc_flag}, 32'b0010);
    tc_clr = 4'b0010;
    @(negedge clk);
    tc_clr = 4'b0000;
    chk_eq("R5 tc cleared", {28'd0, tc_flag}, 32'd0);
    pos_clr = 4'b0010;
    @(negedge clk);
    pos_clr = 4'b0000;
    pulse_rescan();
    wait_valid("R4 after clear");
    chk_eq("R4 pos cleared", {15'd0, xfer_pos}, 32'd0);
    accept(17'd2);
    wait_idle();
    ch_req = 4'b0000; ch_mask = 4'b1111;
  endtask

  // R8: decrement address and full-length boundary on channel 3
  task automatic t_dec();
    ch_mask = 4'b0111; ch_req = 4'b1000; ch_dec = 4'b1000;
    @(negedge clk);
    pulse_rescan();
    wait_valid("R8 ch3 request");
    chk_eq("R8 decrement addr", {1'b0, xfer_addr},
           {1'b0, mk_addr(8'h00, 8'h56, 16'h8000) - 31'd1 - 31'h10000});
    accept(17'h10000);
    chk_eq("R5 tc at max length", {28'd0, tc_flag}, 32'b1000);
    wait_idle();
    ch_req = 4'b0000; ch_mask = 4'b1111; ch_dec = 4'b0000;
  endtask

  initial begin
    rst_n = 1'b0;
    ch_mask = 4'b1111; ch_req = 4'b0000; ch_dec = 4'b0000;
    pos_clr = 4'b0000; tc_clr = 4'b0000;
    rescan = 1'b0; pg_we = 1'b0; pg_hi = 1'b0; pg_off = 3'd0; pg_wdata = 8'h00;
    xfer_ready = 1'b0; xfer_ret = '0;
    base_cnt = {16'hFFFF, 16'h0100, 16'h000F, 16'h0003};
    cur_addr = {16'h8000, 16'h3000, 16'h2000, 16'h1000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pages();
    t_order();
    t_rearm();
    t_dec();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule